// File: doc/BRIEF.md
# I2C Message List Sequencer

This block drives the register port of a byte-level I2C master and carries out a complete list of I2C messages on its own. Each message in the list has a 7-bit target address, a direction, a byte count and a flag that suppresses the repeated START in front of it. The message list and the byte buffers live outside the block. The sequencer selects them through an index and reads or writes them through a simple buffer port.

A single-cycle `go` pulse starts a run. The sequencer first switches the master into polled operation. It then sends START with the first address and moves the payload one byte at a time, polling the transfer-in-progress bit after every command. It turns the bus around between messages, and finishes with STOP. NACK after an address or a written byte, lost arbitration, or a transfer that never completes stops the run early with STOP and flags an error.

At the end the block reports `done`, `error` and the number of bytes it stored from reads. These outputs stay valid until the next run is started.

Top module: `i2c_msg_seq`

## Requirements
- R1: While reset is active, and afterwards until `go`, `done`, `error` and `rd_count` are 0 and the register port makes no access (`reg_wr` = `reg_rd` = 0).
- R2: On `go`, the control register (offset 2) is read and written back with bit 6 (interrupt enable) cleared and all other bits kept. Then the byte {address, read bit} of message 0 is written to the data register (offset 3) and command 0x91 (START) is written to the command register (offset 4).
- R3: Each write byte is taken from the buffer in ascending position order. It is written to the data register, followed by command 0x11.
- R4: Each read byte is requested with command 0x21 (ACK). The last byte of each message is requested with 0x29 (NACK) instead. After completion, the data register is read, the byte is written to the buffer at its position, and `rd_count` increments by one.
- R5: Message 0 always begins with START. Each later message begins with START and its own address unless its no-restart flag is set; with the flag set, it continues directly in its own direction. Zero-length messages contribute only their START, if any.
- R6: After the last message the block writes 0x41 (STOP). It then polls status bit 6 (bus busy) until it is clear, writes 0x01 (IACK) and raises `done` with `error` = 0.
- R7: After every START, write or read command, status (offset 4) is polled. No further data command is issued while bit 1 (transfer in progress) is set.
- R8: Status bit 5 (arbitration lost) seen at any completion aborts the run: STOP, busy wait, IACK, then `done` = 1 and `error` = 1. A read that completes with bit 5 set is not stored.
- R9: Status bit 7 (NACK) at the completion of an address or write byte aborts the run the same way. Bit 7 at the completion of a read is ignored.
- R10: If bit 1 is still set on the TMO_CYCLES-th consecutive status poll, the run aborts with STOP and `error` = 1.
- R11: `done` and `error` hold their values until the next `go`, and `go` while a run is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, accepted only when idle |
| num_msgs | input | MSG_W+1 | Number of messages in the list (at least 1) |
| msg_idx | output | MSG_W | Index of the current message |
| msg_addr | input | 7 | Target address of message `msg_idx` |
| msg_read | input | 1 | Direction of message `msg_idx` (1 = read) |
| msg_len | input | LEN_W | Byte count of message `msg_idx` |
| msg_nostart | input | 1 | No repeated START before message `msg_idx` |
| buf_idx | output | LEN_W | Byte position within the current message |
| buf_rdata | input | 8 | Write byte at (`msg_idx`, `buf_idx`) |
| buf_we | output | 1 | Store strobe for a received byte |
| buf_wdata | output | 8 | Received byte |
| reg_addr | output | 3 | Master register offset |
| reg_wr | output | 1 | Master register write |
| reg_rd | output | 1 | Master register read |
| reg_wdata | output | 8 | Master register write data |
| reg_rdata | input | 8 | Master register read data, valid in the cycle of `reg_rd` |
| done | output | 1 | Run finished |
| error | output | 1 | Run finished by an abort |
| rd_count | output | MSG_W+LEN_W | Bytes stored from reads |

## Verification
The hardest situations to reach from the ports are the abort paths, which require the fault to occur at one exact bus event. Examples are a NACK on the second written byte, lost arbitration in the middle of a read, or a transfer that never ends. The bench surrounds the block with a model of the byte-level master. The model counts issued data commands and injects a chosen fault kind at a chosen command number, either NACK, arbitration loss, or a transfer-in-progress bit that stays set beyond the timeout. Directed cases put faults on address, write and read events. Random message lists, random fault positions and random latencies cover the rest.

// File: rtl/i2c_msg_seq_pkg.sv
package i2c_msg_seq_pkg;

  // register offsets decoded by the byte-level master
  localparam logic [2:0] REG_CTRL    = 3'd2;
  localparam logic [2:0] REG_DATA    = 3'd3;
  localparam logic [2:0] REG_CMDSTAT = 3'd4;

  // command bytes
  localparam logic [7:0] CMD_START   = 8'h91;
  localparam logic [7:0] CMD_STOP    = 8'h41;
  localparam logic [7:0] CMD_WRITE   = 8'h11;
  localparam logic [7:0] CMD_RD_ACK  = 8'h21;
  localparam logic [7:0] CMD_RD_NACK = 8'h29;
  localparam logic [7:0] CMD_IACK    = 8'h01;

  // status and control bit positions
  localparam int ST_TIP   = 1;
  localparam int ST_ARB   = 5;
  localparam int ST_BUSY  = 6;
  localparam int ST_NACK  = 7;
  localparam int CTRL_IEN = 6;

  typedef enum logic [2:0] {
    PH_DONE, PH_START, PH_WRITE, PH_READ, PH_ERROR
  } phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CTRL_RD, S_CTRL_WR, S_WR_DATA, S_WR_CMD, S_WAIT_TIP,
    S_RD_DATA, S_CHECK_END, S_NEW_MSG, S_ISSUE, S_WAIT_BUSY, S_IACK
  } step_e;

endpackage

// File: rtl/i2c_msg_seq_timer.sv
module i2c_msg_seq_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  // expired marks the LIMIT-th sample since the last clear
  assign expired = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_n = cnt_q;
    if (clr)                 cnt_n = '0;
    else if (en && !expired) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/i2c_msg_seq_cursor.sv
module i2c_msg_seq_cursor #(
  parameter int MSG_W = 3,
  parameter int LEN_W = 4,
  parameter int CNT_W = MSG_W + LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pos_inc,
  input  logic             msg_adv,
  input  logic             rd_inc,
  output logic [MSG_W-1:0] msg_idx,
  output logic [LEN_W-1:0] pos,
  output logic [CNT_W-1:0] rd_count
);
  logic [MSG_W-1:0] msg_n;
  logic [LEN_W-1:0] pos_n;
  logic [CNT_W-1:0] cnt_n;
  logic             upd;

  assign upd = clr | pos_inc | msg_adv | rd_inc;

  always_comb begin
    msg_n = msg_idx;
    pos_n = pos;
    cnt_n = rd_count;
    if (clr) begin
      msg_n = '0;
      pos_n = '0;
      cnt_n = '0;
    end else begin
      if (msg_adv) begin
        msg_n = msg_idx + 1'b1;
        pos_n = '0;
      end else if (pos_inc) begin
        pos_n = pos + 1'b1;
      end
      if (rd_inc) cnt_n = rd_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_idx  <= '0;
      pos      <= '0;
      rd_count <= '0;
    end else if (upd) begin
      msg_idx  <= msg_n;
      pos      <= pos_n;
      rd_count <= cnt_n;
    end
  end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_msg_seq_pkg::*;
#(
  parameter int MSG_W      = 3,
  parameter int LEN_W      = 4,
  parameter int TMO_CYCLES = 64,
  localparam int CNT_W     = MSG_W + LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [MSG_W:0]   num_msgs,
  output logic [MSG_W-1:0] msg_idx,
  input  logic [6:0]       msg_addr,
  input  logic             msg_read,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             msg_nostart,
  output logic [LEN_W-1:0] buf_idx,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  output logic [2:0]       reg_addr,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata,
  output logic             done,
  output logic             error,
  output logic [CNT_W-1:0] rd_count
);

  step_e  step_q, step_n;
  phase_e phase_q, phase_n;
  logic [7:0] data_q, data_n, cmd_q, cmd_n, ctrl_q, ctrl_n;
  logic ld_data, ld_cmd, ld_ctrl;
  logic done_q, done_n, err_q, err_n;

  logic cur_clr, pos_inc, msg_adv, rd_inc;
  logic tmr_clr, tmr_en, tmr_exp;
  logic [LEN_W-1:0] pos;

  logic last_msg, at_end, at_final_byte;
  logic st_tip, st_arb, st_busy, st_nack;

  i2c_msg_seq_cursor #(.MSG_W(MSG_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) cursor_i (
    .clk(clk), .rst_n(rst_n), .clr(cur_clr), .pos_inc(pos_inc),
    .msg_adv(msg_adv), .rd_inc(rd_inc),
    .msg_idx(msg_idx), .pos(pos), .rd_count(rd_count)
  );

  i2c_msg_seq_timer #(.LIMIT(TMO_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .expired(tmr_exp)
  );

  assign last_msg      = (({1'b0, msg_idx} + (MSG_W+1)'(1)) == num_msgs);
  assign at_end        = (pos == msg_len);
  assign at_final_byte = (({1'b0, pos} + (LEN_W+1)'(1)) == {1'b0, msg_len});

  assign st_tip  = reg_rdata[ST_TIP];
  assign st_arb  = reg_rdata[ST_ARB];
  assign st_busy = reg_rdata[ST_BUSY];
  assign st_nack = reg_rdata[ST_NACK];

  assign buf_idx   = pos;
  assign buf_wdata = reg_rdata;
  assign done      = done_q;
  assign error     = err_q;

  // next-state and register-port decode
  always_comb begin
    step_n    = step_q;
    phase_n   = phase_q;
    data_n    = data_q;
    cmd_n     = cmd_q;
    ctrl_n    = ctrl_q;
    ld_data   = 1'b0;
    ld_cmd    = 1'b0;
    ld_ctrl   = 1'b0;
    done_n    = done_q;
    err_n     = err_q;
    cur_clr   = 1'b0;
    pos_inc   = 1'b0;
    msg_adv   = 1'b0;
    rd_inc    = 1'b0;
    tmr_clr   = 1'b0;
    tmr_en    = 1'b0;
    reg_addr  = '0;
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    reg_wdata = '0;
    buf_we    = 1'b0;

    unique case (step_q)
      S_IDLE: begin
        if (go) begin
          done_n  = 1'b0;
          err_n   = 1'b0;
          cur_clr = 1'b1;
          step_n  = S_CTRL_RD;
        end
      end
      S_CTRL_RD: begin
        reg_rd   = 1'b1;
        reg_addr = REG_CTRL;
        ctrl_n   = reg_rdata & ~(8'd1 << CTRL_IEN);
        ld_ctrl  = 1'b1;
        step_n   = S_CTRL_WR;
      end
      S_CTRL_WR: begin
        reg_wr    = 1'b1;
        reg_addr  = REG_CTRL;
        reg_wdata = ctrl_q;
        phase_n   = PH_START;
        data_n    = {msg_addr, msg_read};
        cmd_n     = CMD_START;
        ld_data   = 1'b1;
        ld_cmd    = 1'b1;
        step_n    = S_WR_DATA;
      end
      S_WR_DATA: begin
        reg_wr    = 1'b1;
        reg_addr  = REG_DATA;
        reg_wdata = data_q;
        step_n    = S_WR_CMD;
      end
      S_WR_CMD: begin
        reg_wr    = 1'b1;
        reg_addr  = REG_CMDSTAT;
        reg_wdata = cmd_q;
        tmr_clr   = 1'b1;
        step_n    = (cmd_q == CMD_STOP) ? S_WAIT_BUSY : S_WAIT_TIP;
      end
      S_WAIT_TIP: begin
        reg_rd   = 1'b1;
        reg_addr = REG_CMDSTAT;
        tmr_en   = 1'b1;
        if (st_tip) begin
          if (tmr_exp) begin
            phase_n = PH_ERROR;
            cmd_n   = CMD_STOP;
            ld_cmd  = 1'b1;
            step_n  = S_WR_CMD;
          end
        end else if (st_arb) begin
          phase_n = PH_ERROR;
          cmd_n   = CMD_STOP;
          ld_cmd  = 1'b1;
          step_n  = S_WR_CMD;
        end else if (phase_q == PH_READ) begin
          step_n = S_RD_DATA;
        end else if (st_nack) begin
          phase_n = PH_ERROR;
          cmd_n   = CMD_STOP;
          ld_cmd  = 1'b1;
          step_n  = S_WR_CMD;
        end else begin
          phase_n = msg_read ? PH_READ : PH_WRITE;
          step_n  = S_CHECK_END;
        end
      end
      S_RD_DATA: begin
        reg_rd   = 1'b1;
        reg_addr = REG_DATA;
        buf_we   = 1'b1;
        pos_inc  = 1'b1;
        rd_inc   = 1'b1;
        step_n   = S_CHECK_END;
      end
      S_CHECK_END: begin
        if (at_end) begin
          if (last_msg) begin
            phase_n = PH_DONE;
            cmd_n   = CMD_STOP;
            ld_cmd  = 1'b1;
            step_n  = S_WR_CMD;
          end else begin
            msg_adv = 1'b1;
            step_n  = S_NEW_MSG;
          end
        end else begin
          step_n = S_ISSUE;
        end
      end
      S_NEW_MSG: begin
        if (!msg_nostart) begin
          phase_n = PH_START;
          data_n  = {msg_addr, msg_read};
          cmd_n   = CMD_START;
          ld_data = 1'b1;
          ld_cmd  = 1'b1;
          step_n  = S_WR_DATA;
        end else begin
          phase_n = msg_read ? PH_READ : PH_WRITE;
          step_n  = S_CHECK_END;
        end
      end
      S_ISSUE: begin
        if (phase_q == PH_READ) begin
          cmd_n  = at_final_byte ? CMD_RD_NACK : CMD_RD_ACK;
          ld_cmd = 1'b1;
          step_n = S_WR_CMD;
        end else begin
          data_n  = buf_rdata;
          ld_data = 1'b1;
          pos_inc = 1'b1;
          cmd_n   = CMD_WRITE;
          ld_cmd  = 1'b1;
          step_n  = S_WR_DATA;
        end
      end
      S_WAIT_BUSY: begin
        reg_rd   = 1'b1;
        reg_addr = REG_CMDSTAT;
        tmr_en   = 1'b1;
        if (!st_busy) begin
          step_n = S_IACK;
        end else if (tmr_exp) begin
          phase_n = PH_ERROR;
          step_n  = S_IACK;
        end
      end
      S_IACK: begin
        reg_wr    = 1'b1;
        reg_addr  = REG_CMDSTAT;
        reg_wdata = CMD_IACK;
        done_n    = 1'b1;
        err_n     = (phase_q == PH_ERROR);
        step_n    = S_IDLE;
      end
      default: step_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= S_IDLE;
      phase_q <= PH_DONE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      step_q  <= step_n;
      phase_q <= phase_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (ld_data) data_q <= data_n;
      if (ld_cmd)  cmd_q  <= cmd_n;
      if (ld_ctrl) ctrl_q <= ctrl_n;
    end
  end

endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk
  import i2c_msg_seq_pkg::*;
#(
  parameter int MSG_W = 3,
  parameter int LEN_W = 4,
  localparam int CNT_W = MSG_W + LEN_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             done,
  input logic             error,
  input logic [CNT_W-1:0] rd_count,
  input logic             buf_we,
  input logic [2:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [7:0]       reg_wdata
);

  // R7: one register access per cycle
  a_r7_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R1: a finished block leaves the register port quiet
  a_r1_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!reg_wr && !reg_rd));

  // R6: done rises only right after the IACK command
  a_r6_done_after_iack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(reg_wr && reg_addr == REG_CMDSTAT && reg_wdata == CMD_IACK));

  // R11: done holds until the next go
  a_r11_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> done);

  // R11: error holds while done holds
  a_r11_error_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> $stable(error));

  // R8: error is only reported with a finished run
  a_r8_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R4: bytes are stored only while the data register is read
  a_r4_store_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (reg_rd && reg_addr == REG_DATA));

  // R4: rd_count moves only with a store
  a_r4_count_with_store: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_we && !go) |=> $stable(rd_count));

  // R2: START follows a data register write
  a_r2_start_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_CMDSTAT && reg_wdata == CMD_START)
      |-> $past(reg_wr && reg_addr == REG_DATA));

  // R3: a write command follows a data register write
  a_r3_write_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_CMDSTAT && reg_wdata == CMD_WRITE)
      |-> $past(reg_wr && reg_addr == REG_DATA));

endmodule

bind i2c_msg_seq i2c_msg_seq_chk #(.MSG_W(MSG_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .done(done), .error(error),
  .rd_count(rd_count), .buf_we(buf_we), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata)
);

// File: tb/i2c_msg_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_msg_seq_tb_top;
  localparam int MSG_W = 3, LEN_W = 4, CNT_W = 7, TMO = 64;
  localparam int NMAX = 8, LMAX = 16, LOGN = 256;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, go;
  logic [MSG_W:0] num_msgs;
  logic [MSG_W-1:0] msg_idx;
  logic [6:0] msg_addr;
  logic msg_read, msg_nostart, buf_we, reg_wr, reg_rd, done, error;
  logic [LEN_W-1:0] msg_len, buf_idx;
  logic [7:0] buf_rdata, buf_wdata, reg_wdata, reg_rdata;
  logic [2:0] reg_addr;
  logic [CNT_W-1:0] rd_count;

  // message list
  logic [6:0] m_addr [NMAX];
  bit         m_rd   [NMAX];
  int         m_len  [NMAX];
  bit         m_nost [NMAX];
  logic [7:0] wbuf [NMAX][LMAX];
  logic [7:0] rbuf [NMAX][LMAX];
  logic [7:0] exp_rbuf [NMAX][LMAX];
  int nmsg;

  assign num_msgs    = (MSG_W+1)'(nmsg);
  assign msg_addr    = m_addr[msg_idx];
  assign msg_read    = m_rd[msg_idx];
  assign msg_len     = LEN_W'(m_len[msg_idx]);
  assign msg_nostart = m_nost[msg_idx];
  assign buf_rdata   = wbuf[msg_idx][buf_idx];

  i2c_msg_seq #(.MSG_W(MSG_W), .LEN_W(LEN_W), .TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .num_msgs(num_msgs), .msg_idx(msg_idx),
    .msg_addr(msg_addr), .msg_read(msg_read), .msg_len(msg_len),
    .msg_nostart(msg_nostart), .buf_idx(buf_idx), .buf_rdata(buf_rdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done(done), .error(error), .rd_count(rd_count)
  );

  // ---------------- byte-level master model ----------------
  // event codes: 1 START, 2 WRITE, 3 READ ACK, 4 READ NACK, 5 STOP, 6 IACK, 7 other
  int f_kind, f_at, lat, stop_lat;      // fault: 0 none, 1 nack, 2 arb, 3 hang
  logic [7:0] ctrl_init, ctrl_r, dreg;
  int tip_cnt, stop_cnt, ev_n, log_n, tip_viol, busy_viol;
  bit bus_on, st_nack, st_arb, mdl_clr, fire;
  logic [15:0] log_ev [LOGN];
  logic [7:0] rb;

  function automatic logic [7:0] slave_byte(int e);
    return 8'h3C ^ 8'(e * 29);
  endfunction

  always_comb begin
    case (reg_addr)
      3'd2: reg_rdata = ctrl_r;
      3'd3: reg_rdata = dreg;
      3'd4: reg_rdata = {st_nack, bus_on, st_arb, 3'b000, (tip_cnt != 0), 1'b0};
      default: reg_rdata = 8'h00;
    endcase
  end

  task automatic log_push(int t, logic [7:0] v);
    if (log_n < LOGN) log_ev[log_n] = {8'(t), v};
    log_n++;
  endtask

  always @(posedge clk) begin
    if (mdl_clr) begin
      ctrl_r <= ctrl_init; dreg <= 8'h00; tip_cnt <= 0; stop_cnt <= 0;
      bus_on <= 1'b0; st_nack <= 1'b0; st_arb <= 1'b0;
      ev_n = 0; log_n = 0; tip_viol = 0; busy_viol = 0;
      for (int i = 0; i < NMAX; i++)
        for (int j = 0; j < LMAX; j++) rbuf[i][j] <= 8'h00;
    end else begin
      if (tip_cnt != 0) tip_cnt <= tip_cnt - 1;
      if (stop_cnt != 0) begin
        stop_cnt <= stop_cnt - 1;
        if (stop_cnt == 1) bus_on <= 1'b0;
      end
      if (buf_we) rbuf[msg_idx][buf_idx] <= buf_wdata;
      if (reg_wr) begin
        if (reg_addr == 3'd2) ctrl_r <= reg_wdata;
        else if (reg_addr == 3'd3) dreg <= reg_wdata;
        else if (reg_addr == 3'd4) begin
          if (reg_wdata == 8'h91 || reg_wdata == 8'h11 ||
              reg_wdata == 8'h21 || reg_wdata == 8'h29) begin
            if (tip_cnt != 0) tip_viol++;
            fire = (ev_n == f_at);
            if (reg_wdata == 8'h91) begin bus_on <= 1'b1; log_push(1, dreg); end
            else if (reg_wdata == 8'h11) log_push(2, dreg);
            else begin
              rb = slave_byte(ev_n);
              dreg <= rb;
              log_push((reg_wdata == 8'h29) ? 4 : 3, rb);
            end
            tip_cnt <= (fire && f_kind == 3) ? 1000 : lat;
            st_nack <= fire && f_kind == 1;
            st_arb  <= fire && f_kind == 2;
            ev_n++;
          end else if (reg_wdata == 8'h41) begin
            log_push(5, 8'h00);
            tip_cnt <= 0;
            if (stop_lat == 0) bus_on <= 1'b0;
            else stop_cnt <= stop_lat;
          end else if (reg_wdata == 8'h01) begin
            log_push(6, 8'h00);
            if (bus_on) busy_viol++;
          end else log_push(7, reg_wdata);
        end
      end
    end
  end

  // ---------------- expected values ----------------
  logic [15:0] exp_ev [LOGN];
  int exp_n, exp_rd;
  bit exp_err;

  task automatic exp_push(int t, logic [7:0] v);
    if (exp_n < LOGN) exp_ev[exp_n] = {8'(t), v};
    exp_n++;
  endtask

  task automatic build_exp();
    int e; bit ab; logic [7:0] b;
    e = 0; ab = 0; exp_n = 0; exp_rd = 0;
    for (int i = 0; i < NMAX; i++)
      for (int j = 0; j < LMAX; j++) exp_rbuf[i][j] = 8'h00;
    for (int m = 0; m < nmsg && !ab; m++) begin
      if (m == 0 || !m_nost[m]) begin
        exp_push(1, {m_addr[m], m_rd[m]});
        if (e == f_at && f_kind != 0) ab = 1;
        e++;
      end
      for (int p = 0; p < m_len[m] && !ab; p++) begin
        if (m_rd[m]) begin
          b = slave_byte(e);
          exp_push((p == m_len[m] - 1) ? 4 : 3, b);
          if (e == f_at && (f_kind == 2 || f_kind == 3)) ab = 1;
          else begin exp_rbuf[m][p] = b; exp_rd++; end
        end else begin
          exp_push(2, wbuf[m][p]);
          if (e == f_at && f_kind != 0) ab = 1;
        end
        e++;
      end
    end
    exp_push(5, 8'h00);
    exp_push(6, 8'h00);
    exp_err = ab;
  endtask

  // ---------------- checking ----------------
  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic set_msg(int i, logic [6:0] a, bit rd, int len, bit nost);
    m_addr[i] = a; m_rd[i] = rd; m_len[i] = len; m_nost[i] = nost;
    for (int j = 0; j < LMAX; j++) wbuf[i][j] = 8'($urandom);
  endtask

  task automatic run_case(string req, bit mid_go);
    int k, mism, nlog;
    bit rb_ok;
    build_exp();
    ctrl_init = 8'hC0 | 8'($urandom & 32'h3F);
    @(negedge clk) mdl_clr = 1'b1;
    @(negedge clk) mdl_clr = 1'b0;
    go = 1'b1;
    @(negedge clk) go = 1'b0;
    if (mid_go) begin
      repeat (12) @(negedge clk);
      go = 1'b1;
      @(negedge clk) go = 1'b0;
    end
    k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    chk(done, req, "run did not finish", done, 1);
    if (!done) return;
    mism = -1;
    for (int i = 0; i < LOGN; i++) begin
      if (i >= exp_n && i >= log_n) break;
      if (i >= exp_n || i >= log_n || log_ev[i] != exp_ev[i]) begin mism = i; break; end
    end
    if (mism >= 0)
      chk(0, req, $sformatf("bus event %0d (log %0d exp %0d events)", mism, log_n, exp_n),
          (mism < log_n) ? int'(log_ev[mism]) : -1, (mism < exp_n) ? int'(exp_ev[mism]) : -1);
    else chk(1, req, "bus events", 0, 0);
    chk(error == exp_err, "R6/R8/R9/R10", "error flag", error, exp_err);
    chk(int'(rd_count) == exp_rd, "R4", "rd_count", rd_count, exp_rd);
    rb_ok = 1;
    for (int i = 0; i < NMAX; i++)
      for (int j = 0; j < LMAX; j++) if (rbuf[i][j] !== exp_rbuf[i][j]) rb_ok = 0;
    chk(rb_ok, "R4", "stored read bytes match", rb_ok, 1);
    chk(ctrl_r == (ctrl_init & 8'hBF), "R2", "control register", ctrl_r, ctrl_init & 8'hBF);
    chk(tip_viol == 0, "R7", "commands issued during transfer", tip_viol, 0);
    chk(busy_viol == 0, "R6", "IACK while bus busy", busy_viol, 0);
    nlog = log_n;
    repeat (8) @(negedge clk);
    chk(done && error == exp_err && log_n == nlog, "R11", "outputs held while idle",
        {done, error}, {1'b1, exp_err});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; go = 1'b0; mdl_clr = 1'b0; nmsg = 1;
    f_kind = 0; f_at = 0; lat = 2; stop_lat = 2; ctrl_init = 8'hC0;
    for (int i = 0; i < NMAX; i++) set_msg(i, 7'h10, 1'b0, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk(!done && !error && rd_count == 0, "R1", "outputs in reset", {done, error}, 0);
    chk(!reg_wr && !reg_rd, "R1", "register port in reset", {reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!reg_wr && !reg_rd && !done, "R1", "idle after reset", {reg_wr, reg_rd, done}, 0);

    // R3: single write message
    nmsg = 1; set_msg(0, 7'h50, 0, 3, 0); f_kind = 0; run_case("R3", 0);
    // R4: single read message, last byte NACKed
    set_msg(0, 7'h21, 1, 4, 0); run_case("R4", 0);
    // R5: write then read with repeated START
    nmsg = 2; set_msg(0, 7'h3A, 0, 2, 0); set_msg(1, 7'h3A, 1, 3, 0); run_case("R5", 0);
    // R5: first flag ignored, second read continues without START
    set_msg(0, 7'h11, 1, 2, 1); set_msg(1, 7'h22, 1, 2, 1); run_case("R5", 0);
    // R5: zero-length probe then read
    set_msg(0, 7'h7F, 0, 0, 0); set_msg(1, 7'h01, 1, 1, 0); run_case("R5", 0);
    // R9: NACK on address
    nmsg = 1; set_msg(0, 7'h44, 0, 3, 0); f_kind = 1; f_at = 0; run_case("R9", 0);
    // R9: NACK on second written byte
    f_at = 2; run_case("R9", 0);
    // R9: NACK bit during a read is ignored
    set_msg(0, 7'h45, 1, 3, 0); f_at = 2; run_case("R9", 0);
    // R8: arbitration lost in a read
    f_kind = 2; f_at = 2; run_case("R8", 0);
    // R8: arbitration lost on START
    f_at = 0; run_case("R8", 0);
    // R10: transfer never completes
    nmsg = 2; set_msg(0, 7'h12, 0, 2, 0); set_msg(1, 7'h12, 1, 2, 0);
    f_kind = 3; f_at = 3; run_case("R10", 0);
    // R11: go while running is ignored
    f_kind = 0; nmsg = 3; set_msg(0, 7'h30, 0, 5, 0); set_msg(1, 7'h31, 0, 4, 1);
    set_msg(2, 7'h32, 1, 5, 0); lat = 4; run_case("R11", 1);

    // random lists
    for (int r = 0; r < 40; r++) begin
      int fk;
      nmsg = 1 + int'($urandom % NMAX);
      for (int i = 0; i < NMAX; i++)
        set_msg(i, 7'($urandom), 1'($urandom), int'($urandom % 7), 1'($urandom));
      fk = int'($urandom % 6);
      f_kind = (fk < 3) ? 0 : fk - 2;
      f_at = int'($urandom % 20);
      lat = 1 + int'($urandom % 5);
      stop_lat = int'($urandom % 5);
      run_case("R2/R5", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule